// File: doc/BRIEF.md
# Integer Add-Subtract Unit with Overflow Trap

This execution unit serves the integer datapath of a load-store processor core. Each issued operation takes a first register operand, a second register operand or a 16-bit immediate, and a 3-bit operation code. It returns the 32-bit two's complement sum or difference, the destination index, a destination write strobe and an overflow exception flag. The operand bits carry no signedness. The operation code alone decides whether a signed overflow raises an exception. The trapping forms raise it. The non-trapping forms return the wrapped result and write it.

One adder serves every operation. Subtraction inverts the second operand and sets the carry-in. Overflow is judged from the sign bits of the operands and of the result. A registered outcome state machine records what happens to each issued operation and drives the two strobes from that record. Its states are:

- `ST_IDLE`: nothing to report.
- `ST_COMMIT`: the result is written.
- `ST_TRAP`: overflow exception, no write.
- `ST_SKIP`: legal result aimed at register 0, no write.

Every cycle, the state machine takes its next state from the inputs, in this order of priority:

1. No issue, or an undefined code, goes to `ST_IDLE`.
2. A trapping overflow goes to `ST_TRAP`.
3. Destination index 0 goes to `ST_SKIP`.
4. Anything else goes to `ST_COMMIT`.

Top module: `addsub_trap_unit`

## Requirements
- R1: Codes 0 (trapping add) and 1 (non-trapping add) produce res_val = rs_val + rt_val modulo 2^32.
- R2: Codes 4 (trapping subtract) and 5 (non-trapping subtract) produce res_val = rs_val - rt_val modulo 2^32.
- R3: Codes 2 (trapping add-immediate) and 3 (non-trapping add-immediate) produce res_val = rs_val + sign-extended imm16 modulo 2^32, and rt_val does not affect the result.
- R4: Codes 0 and 2 set res_trap and clear res_wen when the signed sum falls outside -2^31 .. 2^31-1. This happens when both addends share a sign and the result sign differs from it.
- R5: Code 4 sets res_trap and clears res_wen when the operand signs differ and the result sign differs from rs_val.
- R6: Codes 1, 3 and 5 never set res_trap. They assert res_wen with the wrapped result even when the signed value overflows.
- R7: res_wen is never asserted for destination index 0. A trapping overflow aimed at index 0 still sets res_trap.
- R8: The results of an operation issued at a clock edge appear after that edge and hold for one cycle. A cycle with issue_valid low leaves res_wen and res_trap low in the following cycle, and leaves res_val and res_dest unchanged.
- R9: While rst_n is low, res_val and res_dest are 0 and res_wen and res_trap are low.
- R10: Undefined codes 6 and 7 leave res_wen and res_trap low and leave res_val and res_dest unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 3 | Operation code: 0 add, 1 add no-trap, 2 add-imm, 3 add-imm no-trap, 4 sub, 5 sub no-trap |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate operand, sign-extended |
| dest_idx | input | 5 | Destination register index |
| res_val | output | 32 | Wrapped result |
| res_dest | output | 5 | Destination index of the reported result |
| res_wen | output | 1 | Destination write strobe |
| res_trap | output | 1 | Overflow exception flag |

## Verification
Every result is due in the cycle after the rising edge that captured the operation: the value, the destination, the write strobe and the trap flag. The bench therefore applies each operation on a falling edge, lets one rising edge pass, and compares on the next falling edge, far from any active edge. An idle cycle or an undefined code is checked in that same slot: the strobes must be low and the held value and destination unchanged. Expected values come from a 64-bit signed model of the requirements inside the bench.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned IMM_W  = 16;
    localparam int unsigned IDX_W  = 5;
    localparam int unsigned OP_W   = 3;

    localparam logic [OP_W-1:0] OP_ADD   = 3'd0;
    localparam logic [OP_W-1:0] OP_ADDU  = 3'd1;
    localparam logic [OP_W-1:0] OP_ADDI  = 3'd2;
    localparam logic [OP_W-1:0] OP_ADDIU = 3'd3;
    localparam logic [OP_W-1:0] OP_SUB   = 3'd4;
    localparam logic [OP_W-1:0] OP_SUBU  = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_TRAP   = 2'd2,
        ST_SKIP   = 2'd3
    } out_st_e;

    typedef struct packed {
        logic legal;
        logic use_imm;
        logic is_sub;
        logic traps;
    } op_ctrl_t;

    function automatic op_ctrl_t op_decode(input logic [OP_W-1:0] op);
        op_ctrl_t c;
        c = '0;
        case (op)
            OP_ADD:   c = '{legal: 1'b1, use_imm: 1'b0, is_sub: 1'b0, traps: 1'b1};
            OP_ADDU:  c = '{legal: 1'b1, use_imm: 1'b0, is_sub: 1'b0, traps: 1'b0};
            OP_ADDI:  c = '{legal: 1'b1, use_imm: 1'b1, is_sub: 1'b0, traps: 1'b1};
            OP_ADDIU: c = '{legal: 1'b1, use_imm: 1'b1, is_sub: 1'b0, traps: 1'b0};
            OP_SUB:   c = '{legal: 1'b1, use_imm: 1'b0, is_sub: 1'b1, traps: 1'b1};
            OP_SUBU:  c = '{legal: 1'b1, use_imm: 1'b0, is_sub: 1'b1, traps: 1'b0};
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/addsub_opnd_sel.sv
module addsub_opnd_sel #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 16
) (
    input  logic              use_imm,
    input  logic [DATA_W-1:0] rt_val,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] opnd_b
);

    localparam int unsigned EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    generate
        if (EXT_W > 0) begin : g_sext
            assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        end else begin : g_flat
            assign imm_ext = imm[DATA_W-1:0];
        end
    endgenerate

    assign opnd_b = use_imm ? imm_ext : rt_val;

endmodule

// File: rtl/addsub_adder.sv
module addsub_adder #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum
);

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] cin;

    assign b_eff = b ^ {DATA_W{sub}};
    assign cin   = {{(DATA_W-1){1'b0}}, sub};
    assign sum   = a + b_eff + cin;

endmodule

// File: rtl/addsub_ovf_detect.sv
module addsub_ovf_detect (
    input  logic a_msb,
    input  logic b_msb,
    input  logic sum_msb,
    input  logic is_sub,
    input  logic traps,
    output logic raise
);

    logic signs_agree;
    logic sum_flipped;
    logic ovf;

    assign signs_agree = (a_msb == b_msb);
    assign sum_flipped = (sum_msb != a_msb);

    always_comb begin
        if (is_sub) begin
            ovf = !signs_agree && sum_flipped;
        end else begin
            ovf = signs_agree && sum_flipped;
        end
    end

    assign raise = traps && ovf;

endmodule

// File: rtl/addsub_trap_unit.sv
module addsub_trap_unit
    import addsub_pkg::*;
#(
    parameter int unsigned DATA_W = addsub_pkg::DATA_W,
    parameter int unsigned IMM_W  = addsub_pkg::IMM_W,
    parameter int unsigned IDX_W  = addsub_pkg::IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [IDX_W-1:0]  dest_idx,
    output logic [DATA_W-1:0] res_val,
    output logic [IDX_W-1:0]  res_dest,
    output logic              res_wen,
    output logic              res_trap
);

    localparam int unsigned MSB = DATA_W - 1;

    op_ctrl_t          ctrl;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] sum;
    logic              raise;
    logic              take;

    out_st_e           st_q;
    out_st_e           st_d;
    logic [DATA_W-1:0] val_q;
    logic [IDX_W-1:0]  dest_q;

    assign ctrl = op_decode(op_sel);
    assign take = issue_valid && ctrl.legal;

    addsub_opnd_sel #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) opnd_i (
        .use_imm (ctrl.use_imm),
        .rt_val  (rt_val),
        .imm     (imm16),
        .opnd_b  (opnd_b)
    );

    addsub_adder #(
        .DATA_W (DATA_W)
    ) adder_i (
        .a   (rs_val),
        .b   (opnd_b),
        .sub (ctrl.is_sub),
        .sum (sum)
    );

    addsub_ovf_detect ovf_i (
        .a_msb   (rs_val[MSB]),
        .b_msb   (opnd_b[MSB]),
        .sum_msb (sum[MSB]),
        .is_sub  (ctrl.is_sub),
        .traps   (ctrl.traps),
        .raise   (raise)
    );

    // next outcome: idle, trap, skip (index 0), commit, in that priority
    always_comb begin
        if (!take) begin
            st_d = ST_IDLE;
        end else if (raise) begin
            st_d = ST_TRAP;
        end else if (dest_idx == '0) begin
            st_d = ST_SKIP;
        end else begin
            st_d = ST_COMMIT;
        end
    end

    // state register and the data it reports
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            val_q  <= '0;
            dest_q <= '0;
        end else begin
            st_q <= st_d;
            if (take) begin
                val_q  <= sum;
                dest_q <= dest_idx;
            end
        end
    end

    // outputs decoded from the outcome state
    always_comb begin
        res_wen  = 1'b0;
        res_trap = 1'b0;
        unique case (st_q)
            ST_IDLE:   ;
            ST_COMMIT: res_wen  = 1'b1;
            ST_TRAP:   res_trap = 1'b1;
            ST_SKIP:   ;
            default:   ;
        endcase
    end

    assign res_val  = val_q;
    assign res_dest = dest_q;

endmodule

// File: rtl/addsub_trap_chk.sv
module addsub_trap_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_valid,
    input logic [2:0]        op_sel,
    input logic [DATA_W-1:0] rs_val,
    input logic [DATA_W-1:0] rt_val,
    input logic [IDX_W-1:0]  dest_idx,
    input logic [DATA_W-1:0] res_val,
    input logic [IDX_W-1:0]  res_dest,
    input logic              res_wen,
    input logic              res_trap
);

    logic [DATA_W-1:0] add_ref;
    logic [DATA_W-1:0] sub_ref;

    assign add_ref = rs_val + rt_val;
    assign sub_ref = rs_val - rt_val;

    // R1
    a_r1_wrapped_add: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && op_sel == 3'd1) |=> (res_val == $past(add_ref)));

    // R2
    a_r2_wrapped_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && op_sel == 3'd5) |=> (res_val == $past(sub_ref)));

    // R4 R5
    a_r4_trap_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        res_trap |-> !res_wen);

    // R6
    a_r6_no_trap_unsigned: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && (op_sel == 3'd1 || op_sel == 3'd3 || op_sel == 3'd5))
        |=> !res_trap);

    // R7
    a_r7_zero_dest_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && dest_idx == '0) |=> !res_wen);

    // R8
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> (!res_wen && !res_trap && $stable(res_val) && $stable(res_dest)));

    // R10
    a_r10_bad_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && op_sel > 3'd5) |=> (!res_wen && !res_trap && $stable(res_val)));

    // R9
    always_comb begin
        if (!rst_n) begin
            a_r9_reset_quiet: assert (!res_wen && !res_trap);
        end
    end

endmodule

bind addsub_trap_unit addsub_trap_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .op_sel      (op_sel),
    .rs_val      (rs_val),
    .rt_val      (rt_val),
    .dest_idx    (dest_idx),
    .res_val     (res_val),
    .res_dest    (res_dest),
    .res_wen     (res_wen),
    .res_trap    (res_trap)
);

// File: tb/addsub_trap_unit_tb_top.sv
`timescale 1ns/1ps
module addsub_trap_unit_tb_top;

    logic        clk;
    logic        rst_n;
    logic        issue_valid;
    logic [2:0]  op_sel;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [15:0] imm16;
    logic [4:0]  dest_idx;
    logic [31:0] res_val;
    logic [4:0]  res_dest;
    logic        res_wen;
    logic        res_trap;

    int n_checks;
    int n_fails;
    bit done;

    logic [31:0] last_val;
    logic [4:0]  last_dest;

    addsub_trap_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .op_sel      (op_sel),
        .rs_val      (rs_val),
        .rt_val      (rt_val),
        .imm16       (imm16),
        .dest_idx    (dest_idx),
        .res_val     (res_val),
        .res_dest    (res_dest),
        .res_wen     (res_wen),
        .res_trap    (res_trap)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // bench model derived from the requirements
    task automatic model(input logic [2:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] imm,
                         input logic [4:0] dst, output logic [31:0] val,
                         output logic wen, output logic trap);
        longint sa;
        longint sb;
        longint full;
        bit legal;
        bit traps;
        bit ovf;
        sa = longint'($signed(a));
        sb = (op == 3'd2 || op == 3'd3) ? longint'($signed(imm)) : longint'($signed(b));
        full = (op == 3'd4 || op == 3'd5) ? (sa - sb) : (sa + sb);
        legal = (op <= 3'd5);
        traps = (op == 3'd0 || op == 3'd2 || op == 3'd4);
        ovf = (full > 64'sd2147483647) || (full < -64'sd2147483648);
        trap = legal && traps && ovf;
        wen = legal && !trap && (dst != 5'd0);
        val = legal ? full[31:0] : last_val;
    endtask

    // apply on falling edge, capture at rising edge, compare on next falling edge
    task automatic run_op(input string tag, input logic [2:0] op,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] imm, input logic [4:0] dst);
        logic [31:0] ev;
        logic ew;
        logic et;
        model(op, a, b, imm, dst, ev, ew, et);
        issue_valid = 1'b1;
        op_sel = op;
        rs_val = a;
        rt_val = b;
        imm16 = imm;
        dest_idx = dst;
        @(negedge clk);
        issue_valid = 1'b0;
        check(tag, "value", res_val, ev);
        check(tag, "dest", {27'd0, res_dest}, (op <= 3'd5) ? {27'd0, dst} : {27'd0, last_dest});
        check(tag, "wen", {31'd0, res_wen}, {31'd0, ew});
        check(tag, "trap", {31'd0, res_trap}, {31'd0, et});
        last_val = res_val;
        last_dest = res_dest;
    endtask

    task automatic t_reset;
        check("R9", "value", res_val, 32'd0);
        check("R9", "dest", {27'd0, res_dest}, 32'd0);
        check("R9", "wen", {31'd0, res_wen}, 32'd0);
        check("R9", "trap", {31'd0, res_trap}, 32'd0);
    endtask

    task automatic t_add;
        run_op("R1", 3'd0, 32'd5, 32'd7, 16'h0000, 5'd8);
        run_op("R1", 3'd1, 32'hFFFF_FFFF, 32'd1, 16'h0000, 5'd9);
        run_op("R1", 3'd1, 32'h1234_5678, 32'h1111_1111, 16'h0000, 5'd31);
    endtask

    task automatic t_sub;
        run_op("R2", 3'd4, 32'd10, 32'd3, 16'h0000, 5'd4);
        run_op("R2", 3'd4, 32'd3, 32'd10, 16'h0000, 5'd5);
        run_op("R2", 3'd5, 32'd0, 32'd1, 16'h0000, 5'd6);
    endtask

    task automatic t_imm;
        run_op("R3", 3'd2, 32'd100, 32'hDEAD_BEEF, 16'hFFFF, 5'd10);
        run_op("R3", 3'd3, 32'd100, 32'h0BAD_F00D, 16'h7FFF, 5'd11);
        run_op("R3", 3'd2, 32'hFFFF_0000, 32'h0, 16'h8000, 5'd12);
    endtask

    task automatic t_add_trap;
        run_op("R4", 3'd0, 32'h7FFF_FFFF, 32'd1, 16'h0000, 5'd1);
        run_op("R4", 3'd0, 32'h8000_0000, 32'h8000_0000, 16'h0000, 5'd2);
        run_op("R4", 3'd2, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd3);
        run_op("R4", 3'd2, 32'h8000_0000, 32'h0, 16'h8000, 5'd3);
        run_op("R4", 3'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0000, 5'd3);
    endtask

    task automatic t_sub_trap;
        run_op("R5", 3'd4, 32'h8000_0000, 32'd1, 16'h0000, 5'd7);
        run_op("R5", 3'd4, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0000, 5'd7);
        run_op("R5", 3'd4, 32'h8000_0000, 32'h8000_0000, 16'h0000, 5'd7);
    endtask

    task automatic t_no_trap;
        run_op("R6", 3'd1, 32'h7FFF_FFFF, 32'd1, 16'h0000, 5'd13);
        run_op("R6", 3'd5, 32'h8000_0000, 32'd1, 16'h0000, 5'd14);
        run_op("R6", 3'd3, 32'h8000_0000, 32'h0, 16'h8000, 5'd15);
    endtask

    task automatic t_zero_dest;
        run_op("R7", 3'd0, 32'd1, 32'd2, 16'h0000, 5'd0);
        run_op("R7", 3'd0, 32'h7FFF_FFFF, 32'd1, 16'h0000, 5'd0);
        run_op("R7", 3'd1, 32'h7FFF_FFFF, 32'd1, 16'h0000, 5'd0);
    endtask

    task automatic t_idle;
        run_op("R8", 3'd0, 32'd40, 32'd2, 16'h0000, 5'd20);
        issue_valid = 1'b0;
        op_sel = 3'd0;
        rs_val = 32'hAAAA_AAAA;
        @(negedge clk);
        check("R8", "idle value", res_val, last_val);
        check("R8", "idle dest", {27'd0, res_dest}, {27'd0, last_dest});
        check("R8", "idle wen", {31'd0, res_wen}, 32'd0);
        check("R8", "idle trap", {31'd0, res_trap}, 32'd0);
    endtask

    task automatic t_bad_code;
        run_op("R10", 3'd6, 32'h7FFF_FFFF, 32'd1, 16'h0000, 5'd21);
        run_op("R10", 3'd7, 32'd3, 32'd4, 16'h0000, 5'd22);
    endtask

    initial begin
        n_checks = 0;
        n_fails = 0;
        done = 1'b0;
        last_val = '0;
        last_dest = '0;
        rst_n = 1'b0;
        issue_valid = 1'b0;
        op_sel = '0;
        rs_val = '0;
        rt_val = '0;
        imm16 = '0;
        dest_idx = '0;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_add;
        t_sub;
        t_imm;
        t_add_trap;
        t_sub_trap;
        t_no_trap;
        t_zero_dest;
        t_idle;
        t_bad_code;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule